// File: doc/BRIEF.md
# Rate-Trimmed Local Time Base

This block keeps the local notion of time for one node on a daisy-chained field bus. An internal nanosecond counter starts at zero after reset and advances on every pulse of a 100 MHz tick input. A programmable 64-bit offset is added to that count to form the node's system time. The sum leaves the block as a registered output.

To keep nodes aligned, a bus master writes a reference time into the block. The block subtracts the programmed line delay from the written value and compares the result with its own system time. It then steers its clock rate for a while. Each tick adds 11 ns while the node is behind the reference, and 9 ns while it is ahead. Once the correction has run out, each tick adds the nominal 10 ns again.

The signed error of the latest comparison is kept in a 32-bit sign-and-magnitude register, so the size of the last correction can be read back. All control words are reached through a 32-bit register port. The port has byte-enabled writes and a read path with one cycle of latency.

Top module: `sysclk_trim`

## Requirements
- R1: After reset the system time output is 0, and the difference register (read at byte address 0x92C) reads 0.
- R2: While no correction is pending, every cycle with `tick` high raises the system time by exactly 10. Cycles without `tick` leave it unchanged.
- R3: System time equals the internal count plus the offset (address 0x920 for the low word, 0x924 for the high word). A new offset value first appears on the output at the next tick, not before.
- R4: Writes to the offset words and to the delay words (0x900 low, 0x904 high) honour `wr_be`: bit b selects data bits 8b+7..8b. Unselected bytes keep their value, and every one of these words reads back.
- R5: A write to the high reference word (0x914) combines its data with the earlier low word (0x910). It then computes err = system_time − (reference − delay) against the system time of that cycle.
- R6: When err < 0, the next min(|err|, TRIM_MAX) ticks each add 11. After them, ticks add 10.
- R7: When err > 0, the next min(err, TRIM_MAX) ticks each add 9. After them, ticks add 10.
- R8: When err = 0, no correction is applied and the difference register records +0 (0x00000000).
- R9: The difference register holds the sign of err in bit 31 (1 = negative) and |err| in bits 30..0. A magnitude of 2^31−1 or more is stored as 0x7FFFFFFF.
- R10: Read data appears on `rd_data` one cycle after `rd_addr` is presented. Reading 0x910 or 0x914 returns the low or high word of the system time.
- R11: A new reference write made while a correction is still running replaces it. The new direction and count start from the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 MHz time-step enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Registered read data |
| sys_time | output | TIME_W | Registered system time in ns |

## Verification
A wrong trim count or direction shows at the very next tick as a step of 9 or 11 where 10 was due, or the reverse. For that reason the bench measures the size of every single step after each reference write. The sweep covers errors on both sides of zero and past the trim limit. A corrupted offset or internal count shows as a wrong absolute value on `sys_time` from the first tick onward. A wrong error sign or saturation shows on the difference register readback, one cycle after the read address is presented.

// File: rtl/sct_pkg.sv
package sct_pkg;
  // Byte addresses of the register port
  localparam int unsigned A_DLY  = 32'h900;  // delay, two words
  localparam int unsigned A_TIME = 32'h910;  // reference write / system time read
  localparam int unsigned A_OFS  = 32'h920;  // offset, two words
  localparam int unsigned A_DIFF = 32'h92C;  // last error, sign-magnitude

  localparam int INC_W = 4;
  localparam logic [INC_W-1:0] INC_NOM  = 4'd10;
  localparam logic [INC_W-1:0] INC_FAST = 4'd11;
  localparam logic [INC_W-1:0] INC_SLOW = 4'd9;

  function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                           input logic [31:0] nxt,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? nxt[8*b +: 8] : cur[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sct_regs.sv
module sct_regs
  import sct_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 12,
  parameter int DIFF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TIME_W-1:0] sys_time,
  input  logic [DIFF_W-1:0] diff,
  output logic [TIME_W-1:0] offset,
  output logic [TIME_W-1:0] delay,
  output logic [TIME_W-1:0] ref_val,
  output logic              ref_stb,
  output logic [31:0]       rd_data
);
  localparam int NW = TIME_W / 32;

  logic [31:0] ofs_w [NW];
  logic [31:0] dly_w [NW];
  logic [31:0] stg_w [NW-1];
  logic [NW-1:0] hit_ofs, hit_dly, hit_time;
  logic [31:0] rd_nxt;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      hit_ofs[w]  = wr_en && (wr_addr == ADDR_W'(A_OFS  + 4*w));
      hit_dly[w]  = wr_en && (wr_addr == ADDR_W'(A_DLY  + 4*w));
      hit_time[w] = wr_en && (wr_addr == ADDR_W'(A_TIME + 4*w));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NW; w++) begin
        ofs_w[w] <= '0;
        dly_w[w] <= '0;
      end
      for (int w = 0; w < NW-1; w++) stg_w[w] <= '0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (hit_ofs[w]) ofs_w[w] <= be_merge(ofs_w[w], wr_data, wr_be);
        if (hit_dly[w]) dly_w[w] <= be_merge(dly_w[w], wr_data, wr_be);
      end
      for (int w = 0; w < NW-1; w++)
        if (hit_time[w]) stg_w[w] <= wr_data;
    end
  end

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      offset[32*w +: 32] = ofs_w[w];
      delay[32*w +: 32]  = dly_w[w];
    end
    for (int w = 0; w < NW-1; w++) ref_val[32*w +: 32] = stg_w[w];
    ref_val[TIME_W-1 -: 32] = wr_data;
  end

  assign ref_stb = hit_time[NW-1];

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_W'(A_DIFF)) rd_nxt = diff;
    for (int w = 0; w < NW; w++) begin
      if (rd_addr == ADDR_W'(A_OFS  + 4*w)) rd_nxt = ofs_w[w];
      if (rd_addr == ADDR_W'(A_DLY  + 4*w)) rd_nxt = dly_w[w];
      if (rd_addr == ADDR_W'(A_TIME + 4*w)) rd_nxt = sys_time[32*w +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R4
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_ofs == '0) |=> $stable(offset));

  // R4
  dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_dly == '0) |=> $stable(delay));
endmodule

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int DIFF_W   = 32,
  parameter int TRIM_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ref_stb,
  input  logic [TIME_W-1:0] ref_val,
  input  logic [TIME_W-1:0] delay,
  input  logic [TIME_W-1:0] sys_time,
  output logic [INC_W-1:0]  inc,
  output logic [DIFF_W-1:0] diff
);
  localparam int CW = $clog2(TRIM_MAX + 1);

  logic [TIME_W-1:0] target, err, mag;
  logic              neg, big;
  logic [CW-1:0]     len, cnt_q;
  logic              fast_q;
  logic [DIFF_W-1:0] diff_nxt;

  always_comb begin
    target   = ref_val - delay;
    err      = sys_time - target;
    neg      = err[TIME_W-1];
    mag      = neg ? (~err + 1'b1) : err;
    big      = |mag[TIME_W-1:DIFF_W-1];
    diff_nxt = {neg, big ? {(DIFF_W-1){1'b1}} : mag[DIFF_W-2:0]};
    len      = (mag > TIME_W'(TRIM_MAX)) ? CW'(TRIM_MAX) : mag[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
      diff   <= '0;
    end else if (ref_stb) begin
      cnt_q  <= len;
      fast_q <= neg;
      diff   <= diff_nxt;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign inc = (cnt_q == '0) ? INC_NOM : (fast_q ? INC_FAST : INC_SLOW);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q != '0) && !ref_stb) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  trim_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(TRIM_MAX));

  // R9
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    diff[DIFF_W-1] |-> (diff[DIFF_W-2:0] != '0));

  // R5
  diff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_stb |=> $stable(diff));
endmodule

// File: rtl/sct_counter.sv
module sct_counter
  import sct_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [INC_W-1:0]  inc,
  input  logic [TIME_W-1:0] offset,
  output logic [TIME_W-1:0] sys_time
);
  logic [TIME_W-1:0] int_q, int_nxt;

  assign int_nxt = int_q + TIME_W'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q    <= '0;
      sys_time <= '0;
    end else if (tick) begin
      int_q    <= int_nxt;
      sys_time <= int_nxt + offset;
    end
  end

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((int_q - $past(int_q)) == TIME_W'(9) ||
              (int_q - $past(int_q)) == TIME_W'(10) ||
              (int_q - $past(int_q)) == TIME_W'(11)));

  // R3
  sys_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sys_time));
endmodule

// File: rtl/sysclk_trim.sv
module sysclk_trim
  import sct_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int ADDR_W   = 12,
  parameter int TRIM_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [TIME_W-1:0] sys_time
);
  localparam int DIFF_W = 32;

  logic [TIME_W-1:0] offset, delay, ref_val;
  logic              ref_stb;
  logic [INC_W-1:0]  inc;
  logic [DIFF_W-1:0] diff;

  sct_regs #(.TIME_W(TIME_W), .ADDR_W(ADDR_W), .DIFF_W(DIFF_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
    .sys_time(sys_time), .diff(diff), .offset(offset), .delay(delay),
    .ref_val(ref_val), .ref_stb(ref_stb), .rd_data(rd_data)
  );

  sct_ctrl #(.TIME_W(TIME_W), .DIFF_W(DIFF_W), .TRIM_MAX(TRIM_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .ref_stb(ref_stb),
    .ref_val(ref_val), .delay(delay), .sys_time(sys_time),
    .inc(inc), .diff(diff)
  );

  sct_counter #(.TIME_W(TIME_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .inc(inc),
    .offset(offset), .sys_time(sys_time)
  );
endmodule

// File: tb/test_sysclk_trim.sv
`timescale 1ns/1ps
module test_sysclk_trim;
  localparam int TMAX = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] sys_time;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] dly = '0;

  always #4 clk = ~clk;

  sysclk_trim #(.TIME_W(64), .ADDR_W(12), .TRIM_MAX(TMAX)) i_sysclk_trim (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
    .rd_data(rd_data), .sys_time(sys_time)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk) rd_addr = a;
    @(negedge clk) d = rd_data;
  endtask

  function automatic logic [31:0] sm(input longint e);
    logic [63:0] m;
    m = (e < 0) ? 64'(-e) : 64'(e);
    if (m > 64'h7FFF_FFFF) m = 64'h7FFF_FFFF;
    return {(e < 0), m[30:0]};
  endfunction

  // Writes a reference that yields error e against the current system time
  task automatic ref_err(input longint e);
    logic [63:0] v;
    v = sys_time - 64'(e) + dly;
    wr(12'h910, v[31:0], 4'hF);
    wr(12'h914, v[63:32], 4'hF);
  endtask

  task automatic ticks_expect(input string req, input int n, input int inc);
    logic [63:0] s0;
    for (int k = 0; k < n; k++) begin
      s0 = sys_time;
      step();
      chk(req, sys_time - s0, 64'(inc));
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", sys_time, 64'd0);
    rd(12'h92C, d); chk("R1", 64'(d), 64'd0);
    // R2 nominal stepping, and no change without tick
    ticks_expect("R2", 5, 10);
    repeat (3) @(negedge clk);
    chk("R2", sys_time, 64'd50);
    // R3 offset appears only at the next tick
    wr(12'h920, 32'h0000_1000, 4'hF);
    chk("R3", sys_time, 64'd50);
    step();
    chk("R3", sys_time, 64'd60 + 64'h1000);
    // R4 byte enables on offset
    wr(12'h920, 32'hAABB_CCDD, 4'b0101);
    rd(12'h920, d); chk("R4", 64'(d), 64'h00BB_10DD);
    wr(12'h924, 32'h1234_5601, 4'b0001);
    rd(12'h924, d); chk("R4", 64'(d), 64'h0000_0001);
    step();
    chk("R3", sys_time, 64'd70 + 64'h1_00BB_10DD);
    // R10 system time readback
    rd(12'h910, d); chk("R10", 64'(d), 64'(sys_time[31:0]));
    rd(12'h914, d); chk("R10", 64'(d), 64'(sys_time[63:32]));
    // R4 byte enables on delay
    wr(12'h900, 32'h0000_0300, 4'hF);
    wr(12'h900, 32'hFFFF_77FF, 4'b0010);
    rd(12'h900, d); chk("R4", 64'(d), 64'h0000_7700);
    wr(12'h904, 32'h0000_0005, 4'hF);
    rd(12'h904, d); chk("R4", 64'(d), 64'h5);
    dly = 64'h5_0000_7700;
    // R5..R9 sweep of errors across zero and past the trim limit
    for (int e = -12; e <= 12; e++) begin
      int n;
      ref_err(longint'(e));
      rd(12'h92C, d); chk((e == 0) ? "R8" : "R9", 64'(d), 64'(sm(longint'(e))));
      n = (e < 0) ? -e : e;
      if (n > TMAX) n = TMAX;
      if (e < 0)      ticks_expect("R6", n, 11);
      else if (e > 0) ticks_expect("R7", n, 9);
      ticks_expect((e == 0) ? "R8" : "R5", 14 - n, 10);
    end
    // R9 magnitude saturation
    ref_err(-64'sd5000000000);
    rd(12'h92C, d); chk("R9", 64'(d), 64'hFFFF_FFFF);
    ticks_expect("R6", TMAX, 11);
    ticks_expect("R6", 2, 10);
    ref_err(64'sd2147483648);
    rd(12'h92C, d); chk("R9", 64'(d), 64'h7FFF_FFFF);
    ticks_expect("R7", TMAX, 9);
    ref_err(64'sd2147483647);
    rd(12'h92C, d); chk("R9", 64'(d), 64'h7FFF_FFFF);
    ticks_expect("R7", TMAX, 9);
    ref_err(64'sd2147483646);
    rd(12'h92C, d); chk("R9", 64'(d), 64'h7FFF_FFFE);
    ticks_expect("R7", TMAX, 9);
    ticks_expect("R7", 1, 10);
    // R11 restart mid-correction
    ref_err(-64'sd6);
    ticks_expect("R11", 2, 11);
    ref_err(64'sd3);
    rd(12'h92C, d); chk("R11", 64'(d), 64'h3);
    ticks_expect("R11", 3, 9);
    ticks_expect("R11", 2, 10);
    // R3 offset change during nominal run keeps int step
    s0 = sys_time;
    wr(12'h920, 32'h00BB_10E0, 4'hF);
    step();
    chk("R3", sys_time - s0, 64'd10 + 64'h3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule